// File: doc/BRIEF.md
# Bus Node Address Claim Controller

This block lets one node on a shared, priority-arbitrated message bus pick a small unique address for itself after power-up and keep it afterwards. It sends claim frames through a frame controller below it and watches the frames that controller receives. It settles clashes with other nodes by comparing message IDs, where a numerically lower ID has the higher priority. Framing, CRC, arbitration and the transceiver all belong to that lower controller. This block sees only a transmit request with a done or error strobe, and a one-cycle strobe for each received frame.

Claims start at address 0 and move upward. The node yields an address when a higher-priority node overrides it. It defends an address against lower-priority nodes by resending its claim with the override code. If a claim frame fails on the bus, the block does not retransmit at once. It waits a fresh pseudo-random number of clock cycles first, which spreads out nodes that collide. Addresses at a fixed spacing are held back for nodes that have been pushed off an address they already held. This keeps a late high-priority node from forcing every other node to renumber.

Top module: `addr_claim`

## Requirements
- R1: After reset `tx_req`, `claimed_valid` and `address_fail` are low. The first claim is requested after a pseudo-random delay of 1 to 2^DELAY_BITS cycles, drawn from a 16-bit LFSR seeded by the SEED parameter.
- R2: The first claim uses address 0 and status 2'b01 (pending).
- R3: Every claim carries `tx_id` equal to `hp_id`. Once `tx_req` rises it stays high, with `tx_addr` and `tx_status` stable, until `tx_done` or `tx_err` is seen.
- R4: On `tx_err`, `tx_req` falls in the next cycle. The same address and status are requested again after a new delay of 1 to 2^DELAY_BITS cycles.
- R5: After `tx_done` a window of WINDOW cycles opens. If no conflicting frame arrives, `claimed_valid` rises exactly WINDOW cycles after the done strobe, with `claimed_addr` equal to the claimed address.
- R6: A received frame with the node's address, status 2'b10 (override) and `rx_id` <= `hp_id` makes the block request the next valid address with status 2'b01 in the following cycle.
- R7: A received frame with the node's address and `rx_id` > `hp_id` makes the block request the same address again, with status 2'b10, in the following cycle. This holds whatever the frame's status.
- R8: While an address is held, frames are still monitored. A conflicting frame drops `claimed_valid` and is resolved as in R6 or R7.
- R9: An address a with a % RSV_SPACING == RSV_SPACING-1 is reserved. Such addresses are skipped until the node has been bumped out of a held address. From then on they may be claimed.
- R10: When no valid address above the current one remains (addresses run to MAX_ADDR), a yield raises `address_fail`. After that `tx_req` never rises again.
- R11: A frame has no effect when its address differs from the node's. It also has no effect when it has the same address, comes from `rx_id` <= `hp_id` and has a status other than 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_id | input | ID_W | Highest-priority message ID used for claims |
| tx_req | output | 1 | Claim frame request, held until done or error |
| tx_id | output | ID_W | Message ID of the claim frame |
| tx_addr | output | ADDR_W | Source address being claimed |
| tx_status | output | 2 | 00 normal, 01 pending, 10 override |
| tx_done | input | 1 | Strobe: claim frame sent successfully |
| tx_err | input | 1 | Strobe: claim frame ended in a bus error |
| rx_valid | input | 1 | Strobe: a frame was received |
| rx_id | input | ID_W | Message ID of the received frame |
| rx_addr | input | ADDR_W | Source address of the received frame |
| rx_status | input | 2 | Status bits of the received frame |
| claimed_valid | output | 1 | An address is held |
| claimed_addr | output | ADDR_W | The held address |
| address_fail | output | 1 | No valid address remains |

## Verification
The assertions check on every cycle that a pending request keeps its fields stable, that a bus error withdraws the request, and that a done strobe closes the request without reporting a claim. They also check that a reserved address is never requested before the node has been bumped, and that a failed node stays silent. The bench scenarios are needed for the rest. These are the timing of the backoff and of the window, the choice between yielding and defending for each mix of ID and status, the order in which addresses are walked, the moment reserved addresses become usable, and the frames that must be ignored.

// File: rtl/addr_claim.sv
module addr_claim #(
  parameter int ID_W = 11,
  parameter int MAX_ADDR = 47,
  parameter int RSV_SPACING = 8,
  parameter int WINDOW = 64,
  parameter int DELAY_BITS = 4,
  parameter logic [15:0] SEED = 16'hACE1,
  parameter int ADDR_W = $clog2(MAX_ADDR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   hp_id,
  output logic              tx_req,
  output logic [ID_W-1:0]   tx_id,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [1:0]        tx_status,
  input  logic              tx_done,
  input  logic              tx_err,
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [1:0]        rx_status,
  output logic              claimed_valid,
  output logic [ADDR_W-1:0] claimed_addr,
  output logic              address_fail
);
  localparam int TMR_W = $clog2(WINDOW + (1 << DELAY_BITS) + 1);
  localparam logic [1:0] ST_NORM = 2'b00, ST_PEND = 2'b01, ST_OVR = 2'b10;

  typedef enum logic [2:0] {S_WAIT, S_SEND, S_WIN, S_HOLD, S_FAIL} st_t;

  st_t              st;
  logic [15:0]      lfsr;
  logic [TMR_W-1:0] tmr;
  logic [ADDR_W-1:0] addr;
  logic [1:0]       status;
  logic             bumped;

  logic [15:0]      lfsr_nx;
  logic [TMR_W-1:0] delay;
  logic             conflict, yield_now, defend_now, nxt_ok;
  logic [ADDR_W-1:0] nxt;

  assign lfsr_nx = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
  assign delay = TMR_W'(lfsr[DELAY_BITS-1:0]) + TMR_W'(1);

  assign conflict = rx_valid && (rx_addr == addr);
  assign yield_now = conflict && (rx_status == ST_OVR) && (rx_id <= hp_id);
  assign defend_now = conflict && (rx_id > hp_id);

  always_comb begin
    nxt = '0;
    nxt_ok = 1'b0;
    for (int a = MAX_ADDR; a >= 0; a--) begin
      if (a > int'(addr) && (bumped || st == S_HOLD || (a % RSV_SPACING) != RSV_SPACING - 1)) begin
        nxt = ADDR_W'(a);
        nxt_ok = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_WAIT;
      lfsr <= SEED;
      tmr <= TMR_W'(SEED[DELAY_BITS-1:0]) + TMR_W'(1);
      addr <= '0;
      status <= ST_PEND;
      bumped <= 1'b0;
    end else begin
      lfsr <= lfsr_nx;
      case (st)
        S_WAIT:
          if (tmr <= TMR_W'(1)) st <= S_SEND;
          else tmr <= tmr - TMR_W'(1);
        S_SEND:
          if (tx_err) begin
            st <= S_WAIT;
            tmr <= delay;
          end else if (tx_done) begin
            st <= S_WIN;
            tmr <= TMR_W'(WINDOW - 1);
          end
        S_WIN, S_HOLD:
          if (yield_now) begin
            if (st == S_HOLD) bumped <= 1'b1;
            if (nxt_ok) begin
              addr <= nxt;
              status <= ST_PEND;
              st <= S_SEND;
            end else begin
              st <= S_FAIL;
            end
          end else if (defend_now) begin
            status <= ST_OVR;
            st <= S_SEND;
          end else if (st == S_WIN) begin
            if (tmr == '0) begin
              st <= S_HOLD;
              status <= ST_NORM;
            end else begin
              tmr <= tmr - TMR_W'(1);
            end
          end
        default: st <= S_FAIL;
      endcase
    end
  end

  assign tx_req = (st == S_SEND);
  assign tx_id = hp_id;
  assign tx_addr = addr;
  assign tx_status = status;
  assign claimed_valid = (st == S_HOLD);
  assign claimed_addr = addr;
  assign address_fail = (st == S_FAIL);

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_done && !tx_err |=> tx_req && $stable(tx_addr) && $stable(tx_status)); // R3
  AST_ERR_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_err |=> !tx_req); // R4
  AST_DONE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_done && !tx_err |=> !tx_req && !claimed_valid); // R5
  AST_CLAIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    claimed_valid |-> int'(claimed_addr) <= MAX_ADDR); // R5
  AST_RSV_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !bumped |-> (int'(tx_addr) % RSV_SPACING) != RSV_SPACING - 1); // R9
  AST_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    address_fail |=> address_fail && !tx_req); // R10
endmodule

// File: tb/test_addr_claim.sv
module test_addr_claim;
  localparam int ID_W = 11, MAX_ADDR = 20, RSV = 8, WIN = 16, DB = 4;
  localparam int ADDR_W = $clog2(MAX_ADDR + 1);
  localparam logic [ID_W-1:0] HP = 11'h100;

  logic clk = 0, rst_n = 0;
  logic tx_req, tx_done = 0, tx_err = 0, rx_valid = 0;
  logic [ID_W-1:0] tx_id, rx_id = '0;
  logic [ADDR_W-1:0] tx_addr, rx_addr = '0, claimed_addr;
  logic [1:0] tx_status, rx_status = '0;
  logic claimed_valid, address_fail;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  addr_claim #(.ID_W(ID_W), .MAX_ADDR(MAX_ADDR), .RSV_SPACING(RSV), .WINDOW(WIN),
               .DELAY_BITS(DB), .SEED(16'h5A3C)) i_addr_claim (
    .clk(clk), .rst_n(rst_n), .hp_id(HP), .tx_req(tx_req), .tx_id(tx_id),
    .tx_addr(tx_addr), .tx_status(tx_status), .tx_done(tx_done), .tx_err(tx_err),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_addr(rx_addr), .rx_status(rx_status),
    .claimed_valid(claimed_valid), .claimed_addr(claimed_addr), .address_fail(address_fail));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_next(input int a, input bit allow);
    for (int b = a + 1; b <= MAX_ADDR; b++)
      if (allow || (b % RSV) != RSV - 1) return b;
    return -1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tx_done = 0; tx_err = 0; rx_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!tx_req && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_done();
    tx_done = 1; @(negedge clk); tx_done = 0;
  endtask

  task automatic pulse_err();
    tx_err = 1; @(negedge clk); tx_err = 0;
  endtask

  task automatic send_rx(input logic [ID_W-1:0] id, input int a, input logic [1:0] s);
    rx_valid = 1; rx_id = id; rx_addr = ADDR_W'(a); rx_status = s;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic claim_here(input int a);
    int n;
    wait_req(n);
    pulse_done();
    repeat (WIN) @(negedge clk);
    chk(claimed_valid && int'(claimed_addr) == a, "R5 claim", int'(claimed_addr), a);
  endtask

  task automatic t_reset();
    int n;
    do_reset();
    chk(!tx_req && !claimed_valid && !address_fail, "R1 reset outputs", int'(tx_req), 0);
    wait_req(n);
    chk(n >= 1 && n <= (1 << DB), "R1 initial delay", n, 1 << DB);
    chk(tx_addr == 0, "R2 first address", int'(tx_addr), 0);
    chk(tx_status == 2'b01, "R2 first status", int'(tx_status), 1);
    chk(tx_id == HP, "R3 claim id", int'(tx_id), int'(HP));
    repeat (3) @(negedge clk);
    chk(tx_req && tx_addr == 0 && tx_status == 2'b01, "R3 request held", int'(tx_req), 1);
  endtask

  task automatic t_error();
    int n;
    do_reset();
    wait_req(n);
    pulse_err();
    chk(!tx_req, "R4 request dropped", int'(tx_req), 0);
    wait_req(n);
    chk(n >= 1 && n <= (1 << DB), "R4 retry delay", n, 1 << DB);
    chk(tx_addr == 0 && tx_status == 2'b01, "R4 same claim", int'(tx_addr), 0);
  endtask

  task automatic t_window();
    int n;
    do_reset();
    wait_req(n);
    pulse_done();
    repeat (WIN - 1) @(negedge clk);
    chk(!claimed_valid, "R5 window still open", int'(claimed_valid), 0);
    @(negedge clk);
    chk(claimed_valid && claimed_addr == 0, "R5 claimed at window end", int'(claimed_valid), 1);
    send_rx(HP + 1, 0, 2'b00);
    chk(!claimed_valid, "R8 hold conflict drops claim", int'(claimed_valid), 0);
    chk(tx_req && tx_status == 2'b10 && tx_addr == 0, "R7 override resend", int'(tx_status), 2);
    pulse_done();
    repeat (WIN) @(negedge clk);
    chk(claimed_valid, "R8 reclaimed", int'(claimed_valid), 1);
    send_rx(HP - 3, 0, 2'b00);
    send_rx(HP - 3, 5, 2'b10);
    chk(claimed_valid && !tx_req && claimed_addr == 0, "R11 frames ignored in hold",
        int'(claimed_valid), 1);
  endtask

  task automatic t_yield();
    int n;
    do_reset();
    wait_req(n);
    pulse_done();
    send_rx(HP, 0, 2'b10);
    chk(tx_req && tx_addr == 1 && tx_status == 2'b01, "R6 yield on equal id", int'(tx_addr), 1);
    pulse_done();
    send_rx(HP - 5, 1, 2'b01);
    chk(!tx_req, "R11 higher-priority pending ignored", int'(tx_req), 0);
    send_rx(HP + 7, 1, 2'b10);
    chk(tx_req && tx_addr == 1 && tx_status == 2'b10, "R7 lower-priority override defended",
        int'(tx_status), 2);
  endtask

  task automatic t_reserved();
    int n, cur;
    do_reset();
    cur = 0;
    for (int k = 0; k < 6; k++) begin
      wait_req(n);
      pulse_done();
      send_rx(HP - 1, cur, 2'b10);
      cur = exp_next(cur, 0);
    end
    chk(tx_addr == 6, "R6 walk to six", int'(tx_addr), 6);
    claim_here(6);
    send_rx(HP - 1, 6, 2'b10);
    chk(tx_req && tx_addr == 7, "R9 bumped node takes reserved", int'(tx_addr), 7);
  endtask

  task automatic t_fail();
    int n, cur;
    do_reset();
    cur = 0;
    while (cur >= 0) begin
      wait_req(n);
      chk(int'(tx_addr) == cur, "R9 initial sequence skips reserved", int'(tx_addr), cur);
      pulse_done();
      send_rx(HP - 1, cur, 2'b10);
      cur = exp_next(cur, 0);
    end
    chk(address_fail && !tx_req, "R10 address exhausted", int'(address_fail), 1);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tx_req) n++;
    end
    chk(n == 0 && address_fail, "R10 stays silent", n, 0);
  endtask

  initial begin
    t_reset();
    t_error();
    t_window();
    t_yield();
    t_reserved();
    t_fail();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule